// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel driven by descriptors in memory. Software writes the base address of a descriptor list and sets the enable bit. A doorbell write then starts the channel. It reads a four-word descriptor, moves a counted number of fixed-size units from a source address to a target address, and then either follows a link to another descriptor or stops. Each unit is one read request of the unit size followed by one write request of the same data. The source and target addresses each either step by the unit size or stay fixed.

Descriptors are found by an 8-bit offset in 16-byte steps from the programmed base. An offset of zero points back at the base, so a fully linked list forms a ring that runs until software stops it. Completion, halt and address-error conditions appear as status bits. A level interrupt is raised only when a descriptor without a link finishes with its interrupt bit set, or when an address error halts the channel.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status register reads 0, the remaining-count register reads 0, `irq` is low and `mem_req` is low.
- R2: Register word addresses are: 0 status, 1 descriptor base, 2 remaining count (read only), 3 doorbell. A doorbell while status bit 0 (enable) is set starts a fetch of four 32-bit words at base+offset, +4, +8, +12. The words are, in that order, command, source, target and count, and each is a 4-byte read with port width code 0. A doorbell with enable clear issues no request.
- R3: A doorbell written while the channel is busy is ignored and adds no request.
- R4: The remaining-count register is loaded from count-word bits [23:0] at fetch and drops by one after each unit's write completes.
- R5: Command bits [10:8] select the unit size (0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes). Each unit is a read at the source with `mem_size_log2` equal to log2 of the unit bytes, then a write of the same data at the target.
- R6: Command bit 23 makes the source address step by the unit size after each unit, and bit 22 does the same for the target. When a bit is clear, that address stays fixed.
- R7: With command bit 0 (link) set, the next descriptor is fetched at base + 16 × count-word bits [31:24]. An offset of 0 refetches the base, so a linked ring repeats.
- R8: When a descriptor with link clear finishes, status bit 3 (terminated) is set and the channel goes idle. `irq` rises only if command bit 1 was set. Linked descriptors that finish raise neither.
- R9: A source or target address not aligned to the unit size, or unit code 7, sets status bits 4 (address error) and 2 (halt), raises `irq`, and moves no data.
- R10: A status write sets enable from bit 0. Writing 0 to bit 2, 3 or 4 clears that flag and drops `irq`. Writing 0 to bit 0 while busy stops all requests.
- R11: A descriptor with a zero count moves no data and completes like any other descriptor.
- R12: `mem_port_w` carries command bits [15:14] on source reads, bits [13:12] on target writes, and 0 on descriptor fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (32) | Byte address |
| mem_size_log2 | output | 3 | log2 of bytes moved |
| mem_port_w | output | 2 | Port width code for this access |
| mem_wdata | output | DW (1024) | Write data, little-endian bytes |
| mem_rdata | input | DW (1024) | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted (and read data valid) |

## Verification
A scoreboard compares every memory request against the fetches and unit moves that the bench predicts. The bench targets six corner cases: a byte-sized chain that jumps to a nonzero link offset, a 16-byte unit, a ring whose zero offset must come back to the base, a doorbell written mid-transfer, a misaligned or unsupported unit, and a zero-count descriptor. A design that mis-scaled the offset would fetch the wrong address. One that honoured the busy doorbell would issue an extra fetch. One that raised the interrupt mid-chain or without the interrupt bit would show `irq` at the wrong time. One that skipped the alignment check would issue data requests after a bad descriptor.

// File: rtl/dma_chain_pkg.sv
// Package: shared types and constants for the descriptor-chained DMA channel.
// Assumes descriptor words are 32 bits and units are powers of two in bytes.
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    // Command word bit positions (decoded by the sequencer)
    localparam int CMD_LINK = 0;
    localparam int CMD_TIE  = 1;
    localparam int CMD_DINC = 22;
    localparam int CMD_SINC = 23;

    // Register word addresses
    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_BASE   = 2'd1;
    localparam logic [1:0] RA_COUNT  = 2'd2;
    localparam logic [1:0] RA_DOOR   = 2'd3;

    // Status bit positions
    localparam int STS_EN   = 0;
    localparam int STS_HALT = 2;
    localparam int STS_TERM = 3;
    localparam int STS_AERR = 4;

    // Maps a unit-size code to log2 of its byte count; 15 marks an unsupported code.
    function automatic logic [3:0] unit_log2(input logic [2:0] code);
        case (code)
            3'd0:    unit_log2 = 4'd2;
            3'd1:    unit_log2 = 4'd0;
            3'd2:    unit_log2 = 4'd1;
            3'd3:    unit_log2 = 4'd4;
            3'd4:    unit_log2 = 4'd5;
            3'd5:    unit_log2 = 4'd6;
            3'd6:    unit_log2 = 4'd7;
            default: unit_log2 = 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/dma_chain_regs.sv
// Module: register file, status flags and interrupt of the DMA channel.
// Does: decodes register writes into enable, base, doorbell start and abort,
//       records completion and error events as sticky flags, drives irq.
// Assumes: a single write strobe per cycle; reads are combinational.
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy_i,
    input  logic          done_i,
    input  logic          tie_i,
    input  logic          err_i,
    input  logic [23:0]   count_i,
    output logic [AW-1:0] base_o,
    output logic          start_o,
    output logic          abort_o,
    output logic          en_o,
    output logic          irq_o
);

    logic          en_q, halt_q, term_q, aerr_q, tie_q;
    logic [AW-1:0] base_q;
    logic          sts_wr, base_wr, door_wr;
    logic          unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:5], reg_wdata[1]};

    // Write decode per register word.
    always_comb begin
        sts_wr  = reg_wr && (reg_addr == RA_STATUS);
        base_wr = reg_wr && (reg_addr == RA_BASE);
        door_wr = reg_wr && (reg_addr == RA_DOOR);
    end

    assign start_o = door_wr && en_q && !busy_i;
    assign abort_o = sts_wr && !reg_wdata[STS_EN];
    assign en_o    = en_q;
    assign base_o  = base_q;
    assign irq_o   = aerr_q || (term_q && tie_q);

    // Base address register.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (base_wr) base_q <= reg_wdata[AW-1:0];
    end

    // Enable and sticky flags: software write first, hardware events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            halt_q <= 1'b0;
            term_q <= 1'b0;
            aerr_q <= 1'b0;
            tie_q  <= 1'b0;
        end else begin
            if (sts_wr) begin
                en_q   <= reg_wdata[STS_EN];
                halt_q <= halt_q && reg_wdata[STS_HALT];
                term_q <= term_q && reg_wdata[STS_TERM];
                aerr_q <= aerr_q && reg_wdata[STS_AERR];
            end
            if (err_i) begin
                halt_q <= 1'b1;
                aerr_q <= 1'b1;
            end
            if (done_i) begin
                term_q <= 1'b1;
                tie_q  <= tie_i;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_STATUS: begin
                reg_rdata[STS_EN]   = en_q;
                reg_rdata[STS_HALT] = halt_q;
                reg_rdata[STS_TERM] = term_q;
                reg_rdata[STS_AERR] = aerr_q;
            end
            RA_BASE:  reg_rdata[AW-1:0] = base_q;
            RA_COUNT: reg_rdata[23:0]   = count_i;
            default:  reg_rdata = '0;
        endcase
    end

    // R10: a flag cleared by software is low in the next cycle unless re-raised
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !reg_wdata[STS_AERR] && !err_i) |=> !aerr_q);

endmodule

// File: rtl/dma_chain_seq.sv
// Module: descriptor sequencer of the DMA channel.
// Does: fetches four-word descriptors, checks alignment, moves units as a
//       read then a write, follows link offsets, reports done and error pulses.
// Assumes: memory holds mem_req/address stable until mem_ack; read data is
//          valid in the cycle mem_ack is high; AW <= 32.
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int AW            = 32,
    parameter int MAX_UNIT_LOG2 = 7,
    localparam int DW           = 8 << MAX_UNIT_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [AW-1:0] base_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          tie_o,
    output logic          err_o,
    output logic [23:0]   count_o,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [2:0]    mem_size_log2,
    output logic [1:0]    mem_port_w,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);

    seq_state_t    state_q;
    logic [31:0]   cmd_q;
    logic [AW-1:0] src_q, dst_q;
    logic [23:0]   cnt_q;
    logic [7:0]    off_q, nxt_q;
    logic [1:0]    widx_q;
    logic [DW-1:0] buf_q;

    logic [3:0]    unit_l2;
    logic          bad_unit, misalign, is_link;
    logic [AW-1:0] ustep, umask;
    logic          unused_cmd;

    assign unused_cmd = ^{cmd_q[31:24], cmd_q[21:16], cmd_q[11], cmd_q[7:2]};

    // Unit decode and alignment test on the loaded descriptor.
    always_comb begin
        unit_l2  = unit_log2(cmd_q[10:8]);
        bad_unit = (unit_l2 > 4'(MAX_UNIT_LOG2));
        ustep    = AW'(1) << unit_l2;
        umask    = ustep - AW'(1);
        misalign = |((src_q | dst_q) & umask);
        is_link  = cmd_q[CMD_LINK];
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign tie_o   = cmd_q[CMD_TIE];
    assign count_o = cnt_q;

    // Memory request outputs as a function of the sequencer state.
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_size_log2 = 3'd2;
        mem_port_w    = 2'd0;
        mem_wdata     = buf_q;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base_i + AW'({off_q, 4'b0000}) + AW'({widx_q, 2'b00});
            end
            ST_READ: begin
                mem_req       = 1'b1;
                mem_addr      = src_q;
                mem_size_log2 = unit_l2[2:0];
                mem_port_w    = cmd_q[15:14];
            end
            ST_WRITE: begin
                mem_req       = 1'b1;
                mem_we        = 1'b1;
                mem_addr      = dst_q;
                mem_size_log2 = unit_l2[2:0];
                mem_port_w    = cmd_q[13:12];
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Sequencer state, descriptor fields, unit buffer and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            off_q   <= '0;
            nxt_q   <= '0;
            widx_q  <= '0;
            buf_q   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            if (abort_i) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i) begin
                            off_q   <= '0;
                            widx_q  <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_ack) begin
                            widx_q <= widx_q + 2'd1;
                            case (widx_q)
                                2'd0: cmd_q <= mem_rdata[31:0];
                                2'd1: src_q <= mem_rdata[AW-1:0];
                                2'd2: dst_q <= mem_rdata[AW-1:0];
                                default: begin
                                    cnt_q   <= mem_rdata[23:0];
                                    nxt_q   <= mem_rdata[31:24];
                                    state_q <= ST_CHECK;
                                end
                            endcase
                        end
                    end
                    ST_CHECK: begin
                        if (bad_unit || misalign) begin
                            err_o   <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (cnt_q == 24'd0) begin
                            if (is_link) begin
                                off_q   <= nxt_q;
                                widx_q  <= '0;
                                state_q <= ST_FETCH;
                            end else begin
                                done_o  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                    ST_READ: begin
                        if (mem_ack) begin
                            buf_q   <= mem_rdata;
                            state_q <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        if (mem_ack) begin
                            cnt_q <= cnt_q - 24'd1;
                            if (cmd_q[CMD_SINC]) src_q <= src_q + ustep;
                            if (cmd_q[CMD_DINC]) dst_q <= dst_q + ustep;
                            if (cnt_q != 24'd1) begin
                                state_q <= ST_READ;
                            end else if (is_link) begin
                                off_q   <= nxt_q;
                                widx_q  <= '0;
                                state_q <= ST_FETCH;
                            end else begin
                                done_o  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R4: each completed unit write lowers the remaining count by one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && mem_ack && !abort_i) |=> (cnt_q == $past(cnt_q) - 24'd1));

    // R5: a pending request keeps its address until acknowledged
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort_i) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/dma_chain_chan.sv
// Module: top of the descriptor-chained DMA channel.
// Does: joins the register file to the descriptor sequencer and exposes the
//       register port, the level interrupt and the memory request port.
// Assumes: one outstanding memory request at a time; AW <= 32.
module dma_chain_chan #(
    parameter int AW            = 32,
    parameter int MAX_UNIT_LOG2 = 7,
    localparam int DW           = 8 << MAX_UNIT_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [2:0]    mem_size_log2,
    output logic [1:0]    mem_port_w,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);

    logic          busy, done, tie, err, start, abort, en;
    logic [23:0]   count;
    logic [AW-1:0] base;

    dma_chain_regs #(.AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy),
        .done_i    (done),
        .tie_i     (tie),
        .err_i     (err),
        .count_i   (count),
        .base_o    (base),
        .start_o   (start),
        .abort_o   (abort),
        .en_o      (en),
        .irq_o     (irq)
    );

    dma_chain_seq #(.AW(AW), .MAX_UNIT_LOG2(MAX_UNIT_LOG2)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .abort_i       (abort),
        .base_i        (base),
        .busy_o        (busy),
        .done_o        (done),
        .tie_o         (tie),
        .err_o         (err),
        .count_o       (count),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_size_log2 (mem_size_log2),
        .mem_port_w    (mem_port_w),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack)
    );

    // R2: the channel only becomes busy while enabled
    assert_start_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> en);

    // R8: the interrupt only rises once the channel has stopped
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

    // R9: an address error leaves no request outstanding
    assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    // R10: clearing enable stops requests in the next cycle
    assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !mem_req);

endmodule

// File: tb/dma_chain_chan_tb_top.sv
// Bench: scoreboard of expected memory requests plus register and irq checks.
module dma_chain_chan_tb_top;

    localparam int AW = 32;
    localparam int ML = 7;
    localparam int DW = 8 << ML;

    localparam logic [31:0] S_EN = 32'h01, S_HALT = 32'h04, S_TERM = 32'h08, S_AERR = 32'h10;
    localparam logic [31:0] C_LINK = 32'h1, C_TIE = 32'h2, C_DINC = 32'h0040_0000, C_SINC = 32'h0080_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [2:0]    mem_size_log2;
    logic [1:0]    mem_port_w;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit irq_watch = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [2:0]  l2;
        logic [1:0]  pw;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [7:0]  mem_b [logic [31:0]];

    always #2.5 clk = ~clk;

    dma_chain_chan #(.AW(AW), .MAX_UNIT_LOG2(ML)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size_log2(mem_size_log2), .mem_port_w(mem_port_w),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem_b.exists(a) ? mem_b[a] : 8'h00;
    endfunction

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {rd_byte(a + 3), rd_byte(a + 2), rd_byte(a + 1), rd_byte(a)};
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem_b[a + 32'(i)] = v[8*i +: 8];
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] cmd, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] cnt);
        wr32(a, cmd); wr32(a + 4, s); wr32(a + 8, d); wr32(a + 12, cnt);
    endtask

    task automatic exp_fetch(input logic [31:0] a, input string tag);
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.we = 0; e.addr = a + 32'(4 * i); e.l2 = 3'd2; e.pw = 2'd0; e.data = '0; e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic exp_acc(input logic we, input logic [31:0] a, input logic [2:0] l2,
                           input logic [1:0] pw, input logic [31:0] data, input string tag);
        exp_t e;
        e.we = we; e.addr = a; e.l2 = l2; e.pw = pw; e.data = data; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic drain();
        do begin @(negedge clk); #1; end while (sb_q.size() != 0);
        repeat (4) @(negedge clk);
    endtask

    // Memory model: one-cycle acknowledge, little-endian byte store.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    for (int i = 0; i < (1 << mem_size_log2); i++)
                        mem_b[mem_addr + 32'(i)] = mem_wdata[8*i +: 8];
                end else begin
                    mem_rdata <= '0;
                    for (int i = 0; i < (1 << mem_size_log2); i++)
                        mem_rdata[8*i +: 8] <= rd_byte(mem_addr + 32'(i));
                end
            end
        end
    end

    // Monitor: pop one expected item per accepted request and compare.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3 unexpected request", {31'd0, mem_we, mem_addr}, 64'd0);
            end else begin
                exp_t e;
                logic [31:0] mask;
                e = sb_q.pop_front();
                chk(mem_we == e.we && mem_addr == e.addr && mem_size_log2 == e.l2 && mem_port_w == e.pw,
                    e.tag, {27'd0, mem_we, mem_port_w, mem_size_log2, mem_addr},
                    {27'd0, e.we, e.pw, e.l2, e.addr});
                if (e.we) begin
                    mask = (e.l2 >= 3'd2) ? 32'hFFFF_FFFF : (e.l2 == 3'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
                    chk((mem_wdata[31:0] & mask) == (e.data & mask), {e.tag, " data"},
                        {32'd0, mem_wdata[31:0] & mask}, {32'd0, e.data & mask});
                end
            end
        end
        if (irq_watch && irq) chk(1'b0, "R8 irq during chain", 64'd1, 64'd0);
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(2'd0, v); chk(v == 32'h0, "R1 status", {32'd0, v}, 64'd0);
        reg_read(2'd2, v); chk(v == 32'h0, "R1 count", {32'd0, v}, 64'd0);
        chk(!irq && !mem_req, "R1 irq/req", {62'd0, irq, mem_req}, 64'd0);

        // R2: doorbell while disabled does nothing
        reg_write(2'd1, 32'h40);
        reg_write(2'd3, 32'h1);
        repeat (10) @(negedge clk);
        chk(!mem_req, "R2 disabled doorbell", {63'd0, mem_req}, 64'd0);
        reg_read(2'd1, v); chk(v == 32'h40, "R2 base readback", {32'd0, v}, 64'h40);

        // R5/R6/R8: single terminated descriptor, 4-byte units, both increment; R3 busy doorbell
        for (int i = 0; i < 3; i++) wr32(32'h100 + 32'(4 * i), 32'hA000_0001 + 32'(i));
        put_desc(32'h40, C_TIE | C_SINC | C_DINC, 32'h100, 32'h200, 32'd3);
        exp_fetch(32'h40, "R2 fetch");
        for (int i = 0; i < 3; i++) begin
            exp_acc(1'b0, 32'h100 + 32'(4 * i), 3'd2, 2'd0, 32'h0, "R6 read step");
            exp_acc(1'b1, 32'h200 + 32'(4 * i), 3'd2, 2'd0, 32'hA000_0001 + 32'(i), "R5 write step");
        end
        reg_write(2'd0, S_EN);
        reg_write(2'd3, 32'h1);
        reg_write(2'd3, 32'h1);
        drain();
        reg_read(2'd0, v); chk(v == (S_EN | S_TERM), "R8 terminated status", {32'd0, v}, {32'd0, S_EN | S_TERM});
        chk(irq, "R8 irq with tie", {63'd0, irq}, 64'd1);
        reg_read(2'd2, v); chk(v == 32'h0, "R4 count at end", {32'd0, v}, 64'd0);
        chk(rd32(32'h208) == 32'hA000_0003, "R6 dst last word", {32'd0, rd32(32'h208)}, 64'hA000_0003);

        // R10: clearing flags drops irq
        reg_write(2'd0, S_EN);
        reg_read(2'd0, v); chk(v == S_EN, "R10 flags cleared", {32'd0, v}, {32'd0, S_EN});
        chk(!irq, "R10 irq cleared", {63'd0, irq}, 64'd0);

        // R7/R12/R5: linked chain, byte units to fixed target, then 16-byte unit
        wr32(32'h1100, 32'h4433_2211);
        for (int i = 0; i < 4; i++) wr32(32'h1300 + 32'(4 * i), 32'hC0DE_0000 + 32'(i));
        put_desc(32'h1000, C_LINK | C_SINC | (32'd1 << 8) | (32'd1 << 14) | (32'd2 << 12),
                 32'h1101, 32'h1200, (32'd3 << 24) | 32'd2);
        put_desc(32'h1030, C_TIE | C_SINC | C_DINC | (32'd3 << 8), 32'h1300, 32'h1400, 32'd1);
        exp_fetch(32'h1000, "R2 chain fetch");
        exp_acc(1'b0, 32'h1101, 3'd0, 2'd1, 32'h0, "R12 src width");
        exp_acc(1'b1, 32'h1200, 3'd0, 2'd2, 32'h22, "R12 dst width");
        exp_acc(1'b0, 32'h1102, 3'd0, 2'd1, 32'h0, "R6 src step byte");
        exp_acc(1'b1, 32'h1200, 3'd0, 2'd2, 32'h33, "R6 dst fixed");
        exp_fetch(32'h1030, "R7 link offset");
        exp_acc(1'b0, 32'h1300, 3'd4, 2'd0, 32'h0, "R5 16-byte read");
        exp_acc(1'b1, 32'h1400, 3'd4, 2'd0, 32'hC0DE_0000, "R5 16-byte write");
        reg_write(2'd1, 32'h1000);
        irq_watch = 1'b1;
        reg_write(2'd3, 32'h1);
        do begin @(negedge clk); #1; end while (sb_q.size() != 0);
        irq_watch = 1'b0;
        repeat (4) @(negedge clk);
        chk(irq, "R8 irq at chain end", {63'd0, irq}, 64'd1);
        chk(rd32(32'h140C) == 32'hC0DE_0003, "R5 16-byte tail", {32'd0, rd32(32'h140C)}, 64'hC0DE_0003);
        reg_write(2'd0, S_EN);

        // R7/R10: ring with zero offset, stopped by writing enable 0
        put_desc(32'h2000, C_LINK, 32'h2100, 32'h2200, 32'd1);
        wr32(32'h2100, 32'h5A5A_0001);
        for (int k = 0; k < 2; k++) begin
            exp_fetch(32'h2000, "R7 ring refetch");
            exp_acc(1'b0, 32'h2100, 3'd2, 2'd0, 32'h0, "R7 ring read");
            exp_acc(1'b1, 32'h2200, 3'd2, 2'd0, 32'h5A5A_0001, "R7 ring write");
        end
        reg_write(2'd1, 32'h2000);
        reg_write(2'd3, 32'h1);
        do begin @(negedge clk); #1; end while (sb_q.size() != 0);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0;
        @(negedge clk); #1; reg_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk(!mem_req, "R10 abort stops requests", {63'd0, mem_req}, 64'd0);
        reg_read(2'd0, v); chk(v == 32'h0, "R10 status after abort", {32'd0, v}, 64'd0);
        chk(!irq, "R8 no irq from ring", {63'd0, irq}, 64'd0);
        reg_write(2'd0, S_EN);

        // R9: misaligned source halts with address error; R4 count loaded
        put_desc(32'h3000, C_TIE, 32'h3102, 32'h3200, 32'd5);
        exp_fetch(32'h3000, "R9 fetch only");
        reg_write(2'd1, 32'h3000);
        reg_write(2'd3, 32'h1);
        drain();
        reg_read(2'd0, v); chk(v == (S_EN | S_HALT | S_AERR), "R9 misalign status", {32'd0, v}, {32'd0, S_EN | S_HALT | S_AERR});
        chk(irq, "R9 irq", {63'd0, irq}, 64'd1);
        reg_read(2'd2, v); chk(v == 32'd5, "R4 count loaded", {32'd0, v}, 64'd5);
        reg_write(2'd0, S_EN);

        // R9: unit code 7 is rejected
        put_desc(32'h3000, 32'd7 << 8, 32'h3100, 32'h3200, 32'd1);
        exp_fetch(32'h3000, "R9 bad unit fetch");
        reg_write(2'd3, 32'h1);
        drain();
        reg_read(2'd0, v); chk(v == (S_EN | S_HALT | S_AERR), "R9 bad unit status", {32'd0, v}, {32'd0, S_EN | S_HALT | S_AERR});
        reg_write(2'd0, S_EN);

        // R11/R8: zero count, no interrupt bit
        put_desc(32'h3000, 32'h0, 32'h3100, 32'h3200, 32'd0);
        exp_fetch(32'h3000, "R11 fetch only");
        reg_write(2'd3, 32'h1);
        drain();
        reg_read(2'd0, v); chk(v == (S_EN | S_TERM), "R11 zero count done", {32'd0, v}, {32'd0, S_EN | S_TERM});
        chk(!irq, "R8 no irq without tie", {63'd0, irq}, 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule